// File: doc/BRIEF.md
# Ones-Complement Shift and Rotate Unit

This unit holds an 18-bit accumulator and an 18-bit I/O register. It moves their contents one bit position per clock. A 13-bit control word sets four things: the direction, whether the move is a cyclic rotate or a sign-preserving arithmetic shift, which register takes part, and how many steps to make. The two registers can also work as one 36-bit pair, with the accumulator as the upper half. In that mode the I/O register extends the accumulator's magnitude to the right.

The step count is the number of set bits in a 9-bit field, not a binary number. Any one of nine encodings therefore asks for a single step. Software loads the registers through a shared data port while the unit is idle. It then pulses `start` and waits for `done`, and reads the results on the register outputs at any time.

Top module: `shift_rotate_unit`

## Requirements
- R1: After reset, `ac_q`, `io_q`, `busy` and `done` are all zero.
- R2: While `busy` is low, `ld_ac` and `ld_io` copy `ld_data` into the accumulator and the I/O register on the next clock. While `busy` is high, both load strobes are ignored.
- R3: The step count n is the number of ones in `ctrl[8:0]`. After an accepted start, `busy` is high for exactly n cycles and `done` is high for one cycle after them. With n = 0, `done` pulses on the cycle after the start, `busy` stays low and nothing changes.
- R4: `ctrl[12]` sets the direction (1 = right, 0 = left) and `ctrl[11]` sets the kind (1 = arithmetic shift, 0 = rotate). `ctrl[10:9]` picks the operand: 01 is the accumulator, 10 is the I/O register, and 11 is the 36-bit pair {accumulator, I/O}. With 00, no register changes.
- R5: A rotate moves every bit of the selected register, or of the 36-bit pair, around a ring one place per step, so no bit is lost.
- R6: An arithmetic shift keeps the MSB (the sign) fixed and fills each vacated magnitude position with a copy of the sign.
- R7: In a combined arithmetic shift, only the accumulator MSB is the sign. The I/O register MSB is an ordinary magnitude bit in the 35-bit magnitude that follows the sign.
- R8: A `start` that arrives while `busy` is high is ignored. The running operation completes unchanged.
- R9: A register that the select field does not pick keeps its value for the whole operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_ac | input | 1 | Load accumulator from `ld_data` (idle only) |
| ld_io | input | 1 | Load I/O register from `ld_data` (idle only) |
| ld_data | input | 18 | Load value |
| start | input | 1 | Begin the operation described by `ctrl` |
| ctrl | input | 13 | Direction, kind, select and count field |
| ac_q | output | 18 | Accumulator contents |
| io_q | output | 18 | I/O register contents |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `start`, `ld_ac` and `ld_io` have known values on every clock after reset. They also assume `ctrl` is valid on the edge where a start is accepted. The bench drives every input on the falling edge and holds `ctrl` steady around each start. It raises stray starts and loads during a busy window only on purpose, to test that they are rejected. Random control words cover all select codes, both kinds, both directions and counts from zero to nine. The operand values are random, including negative ones.

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit #(
  parameter int W  = 18,
  parameter int CW = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_ac,
  input  logic            ld_io,
  input  logic [W-1:0]    ld_data,
  input  logic            start,
  input  logic [CW+3:0]   ctrl,
  output logic [W-1:0]    ac_q,
  output logic [W-1:0]    io_q,
  output logic            busy,
  output logic            done
);
  localparam int NW = $clog2(CW + 1);
  localparam int PW = 2 * W;

  logic          dir_q, kind_q;
  logic [1:0]    sel_q;
  logic [NW-1:0] rem_q;
  logic [NW-1:0] steps;

  always_comb begin
    steps = '0;
    for (int i = 0; i < CW; i++) steps = steps + NW'(ctrl[i]);
  end

  function automatic logic [W-1:0] step_one(input logic [W-1:0] v, input logic d, input logic k);
    if (!k) return d ? {v[0], v[W-1:1]} : {v[W-2:0], v[W-1]};
    return d ? {v[W-1], v[W-1], v[W-2:1]} : {v[W-1], v[W-3:0], v[W-1]};
  endfunction

  function automatic logic [PW-1:0] step_pair(input logic [PW-1:0] v, input logic d, input logic k);
    if (!k) return d ? {v[0], v[PW-1:1]} : {v[PW-2:0], v[PW-1]};
    return d ? {v[PW-1], v[PW-1], v[PW-2:1]} : {v[PW-1], v[PW-3:0], v[PW-1]};
  endfunction

  logic [PW-1:0] pair_nx;
  assign pair_nx = step_pair({ac_q, io_q}, dir_q, kind_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ac_q   <= '0;
      io_q   <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
      dir_q  <= 1'b0;
      kind_q <= 1'b0;
      sel_q  <= 2'b00;
      rem_q  <= '0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        case (sel_q)
          2'b01:   ac_q <= step_one(ac_q, dir_q, kind_q);
          2'b10:   io_q <= step_one(io_q, dir_q, kind_q);
          2'b11:   {ac_q, io_q} <= pair_nx;
          default: ;
        endcase
        rem_q <= rem_q - NW'(1);
        if (rem_q == NW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else begin
        if (ld_ac) ac_q <= ld_data;
        if (ld_io) io_q <= ld_data;
        if (start) begin
          dir_q  <= ctrl[CW+3];
          kind_q <= ctrl[CW+2];
          sel_q  <= ctrl[CW+1:CW];
          rem_q  <= steps;
          if (steps == '0) done <= 1'b1;
          else             busy <= 1'b1;
        end
      end
    end
  end

  a_r3_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rem_q != NW'(1)) |=> busy);
  a_r3_finish: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rem_q == NW'(1)) |=> (done && !busy));
  a_r3_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r2_ac_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ld_ac) |=> $stable(ac_q));
  a_r2_io_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !ld_io) |=> $stable(io_q));
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(sel_q) && $stable(dir_q) && $stable(kind_q)));
  a_r6_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && kind_q && sel_q[0]) |=> (ac_q[W-1] == $past(ac_q[W-1])));
  a_r5_ring: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !kind_q && sel_q == 2'b11) |=>
      ($countones({ac_q, io_q}) == $countones($past({ac_q, io_q}))));
  a_r9_io_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !sel_q[1]) |=> $stable(io_q));
  a_r9_ac_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !sel_q[0]) |=> $stable(ac_q));
endmodule

// File: tb/test_shift_rotate_unit.sv
`timescale 1ns/1ps
module test_shift_rotate_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_ac = 1'b0, ld_io = 1'b0, start = 1'b0;
  logic [17:0] ld_data = '0;
  logic [12:0] ctrl = '0;
  logic [17:0] ac_q, io_q;
  logic busy, done;
  int checks = 0, failures = 0;
  logic [17:0] ac_m = '0, io_m = '0;

  shift_rotate_unit i_shift_rotate_unit (
    .clk(clk), .rst_n(rst_n), .ld_ac(ld_ac), .ld_io(ld_io), .ld_data(ld_data),
    .start(start), .ctrl(ctrl), .ac_q(ac_q), .io_q(io_q), .busy(busy), .done(done));

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] m18(input logic [17:0] v, input logic r, input logic a);
    logic s;
    logic [16:0] m;
    if (!a) return r ? ((v >> 1) | (v << 17)) : ((v << 1) | (v >> 17));
    s = v[17];
    m = v[16:0];
    m = r ? ((m >> 1) | (17'(s) << 16)) : ((m << 1) | 17'(s));
    return {s, m};
  endfunction

  function automatic logic [35:0] m36(input logic [35:0] v, input logic r, input logic a);
    logic s;
    logic [34:0] m;
    if (!a) return r ? ((v >> 1) | (v << 35)) : ((v << 1) | (v >> 35));
    s = v[35];
    m = v[34:0];
    m = r ? ((m >> 1) | (35'(s) << 34)) : ((m << 1) | 35'(s));
    return {s, m};
  endfunction

  function automatic logic [35:0] model(input logic [17:0] a, input logic [17:0] b, input logic [12:0] c);
    logic [35:0] p;
    p = {a, b};
    for (int i = 0; i < $countones(c[8:0]); i++) begin
      case (c[10:9])
        2'b01: p[35:18] = m18(p[35:18], c[12], c[11]);
        2'b10: p[17:0]  = m18(p[17:0], c[12], c[11]);
        2'b11: p = m36(p, c[12], c[11]);
        default: ;
      endcase
    end
    return p;
  endfunction

  function automatic string tag_of(input logic [12:0] c);
    if (c[10:9] == 2'b00) return "R9";
    if (!c[11]) return "R5";
    if (c[10:9] == 2'b11) return "R7";
    return "R6";
  endfunction

  task automatic load(input logic [17:0] a, input logic [17:0] b);
    @(negedge clk); ld_ac = 1'b1; ld_data = a;
    @(negedge clk); ld_ac = 1'b0; ld_io = 1'b1; ld_data = b;
    @(negedge clk); ld_io = 1'b0;
    ac_m = a; io_m = b;
    chk("R2 load", {ac_q, io_q}, {a, b});
  endtask

  task automatic run(input logic [12:0] c, input bit poke_start, input bit poke_load, input string tg);
    logic [35:0] exp;
    int n, cyc;
    exp = model(ac_m, io_m, c);
    n = $countones(c[8:0]);
    @(negedge clk); ctrl = c; start = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 0;
    while (busy && cyc < 40) begin
      if (cyc == 0 && poke_start) begin start = 1'b1; ctrl = ~c; end
      if (cyc == 0 && poke_load) begin ld_ac = 1'b1; ld_io = 1'b1; ld_data = 18'h2a5a5; end
      @(negedge clk);
      start = 1'b0; ld_ac = 1'b0; ld_io = 1'b0;
      cyc++;
    end
    chk("R3 busy cycles", 36'(cyc), 36'(n));
    chk("R3 done pulse", {35'd0, done}, 36'd1);
    chk(tg, {ac_q, io_q}, exp);
    @(negedge clk);
    chk("R3 done clears", {35'd0, done}, 36'd0);
    ac_m = exp[35:18]; io_m = exp[17:0];
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset", {ac_q, io_q, busy, done}, 38'd0);

    load(18'o400001, 18'o123456);
    run({1'b1, 1'b1, 2'b01, 9'b000010101}, 0, 0, "R6 negative sar 3");
    chk("R6 explicit", {18'd0, ac_q}, {18'd0, 18'o740000});
    load(18'o000001, 18'o000001);
    run({1'b0, 1'b0, 2'b10, 9'b100000000}, 0, 0, "R4 io rotate left");
    chk("R4 explicit", {18'd0, io_q}, 36'o000002);
    run({1'b1, 1'b0, 2'b10, 9'b000000001}, 0, 0, "R4 io rotate right");
    load(18'o200000, 18'o400000);
    run({1'b0, 1'b1, 2'b11, 9'b000000001}, 0, 0, "R7 pair shift left");
    chk("R7 explicit", {ac_q, io_q}, {18'o000001, 18'o000000});
    load(18'o400000, 18'o000000);
    run({1'b1, 1'b1, 2'b11, 9'b111111111}, 0, 0, "R7 pair sar 9");
    run({1'b0, 1'b1, 2'b01, 9'b000000000}, 0, 0, "R3 zero count");
    run({1'b0, 1'b0, 2'b00, 9'b001100000}, 0, 0, "R9 no select");
    run({1'b1, 1'b0, 2'b11, 9'b111111111}, 0, 0, "R5 pair rotate 9");
    load(18'o123456, 18'o654321);
    run({1'b0, 1'b0, 2'b01, 9'b000001111}, 1, 0, "R8 start while busy");
    run({1'b1, 1'b1, 2'b10, 9'b000011100}, 0, 1, "R2 load while busy");

    for (int k = 0; k < 60; k++) begin
      logic [12:0] c;
      load(18'($urandom), 18'($urandom));
      c = 13'($urandom);
      run(c, 0, 0, tag_of(c));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule